// File: doc/BRIEF.md
# Windowed Modular Exponentiation Engine

This block raises a 12-bit base to a 12-bit power modulo an odd 12-bit modulus, returning Z = X^Y mod M. It works with fixed 4-bit windows of the exponent. Every modular product comes from a bit-serial Montgomery multiplier inside the block. Before the scan starts, the engine maps the base into the Montgomery domain and fills a small register bank with the base raised to each power from 2 to 15. It then walks the exponent window by window, starting at the most significant end. Each window after the first begins with four squarings. A window with a nonzero value then takes one multiply by the matching stored power. A window with value zero takes no multiply at all.

The caller presents base, exponent, modulus and the correction factor C = 2^24 mod M, then pulses start. The block copies all four operands into its own registers in that same cycle. It stays busy until the result is ready, then holds done high and keeps the result on its output until the next accepted start. The run time depends on the exponent, so callers wait for done instead of counting cycles.

Top module: `modexp_window`

## Requirements
- R1: For 2^11 < M < 2^12 with M odd, X < M and C = 2^24 mod M, the result presented with done equals X^Y mod M.
- R2: start is sampled only while the block is idle or done. A start pulse during a run is ignored: the run is not restarted, the operands it carries are not taken, and the result is that of the first operands.
- R3: After an accepted start, done is low and busy is high from the next cycle on. Once done rises it stays high, with busy low, until the next start.
- R4: While done stays high, the result output does not change.
- R5: An exponent window equal to zero costs no multiply. Exponents 0x100 and 0x101 differ only in one nonzero last window, as do 0x010 and 0x011. In each pair the second run takes longer, and by the same number of cycles in both pairs.
- R6: An exponent of zero gives the result 1.
- R7: A base of 0 gives 0 for any nonzero exponent. A base of 1 gives 1.
- R8: Whenever done is high, the result is below M.
- R9: Each window value from 1 to 15 selects the matching power of the base. Value 1 uses the mapped base. Values 2 to 15 read bank address value−2. The bank is written at most one entry per cycle.
- R10: After reset, busy and done are low and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; sampled only when idle or done |
| base_i | input | 12 | Base X, must be below M |
| exp_i | input | 12 | Exponent Y |
| mod_i | input | 12 | Odd modulus M |
| corr_i | input | 12 | Correction factor 2^24 mod M |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | High from completion until the next start |
| result_o | output | 12 | X^Y mod M, valid while done is high |

## Verification
The time from start to done depends on the exponent. Each Montgomery product takes the operand width plus a few control cycles, and the number of products depends on how many exponent windows are nonzero. For this reason the checks do not wait a fixed number of cycles. Each one waits, cycle by cycle on the falling edge, for done to rise, with a timeout per run, and reads the result in that same half cycle. The skip of zero windows is checked by measuring the cycles from start to done on exponent pairs that differ in one window and comparing the two differences. The checks on how done behaves are placed one falling edge after the start pulse and many cycles after done rises.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

   // Sequencer states of the windowed exponentiation controller
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_TOMONT,
      ST_ONE,
      ST_POWERS,
      ST_WINDOW,
      ST_SQUARE,
      ST_MULT,
      ST_FROMMONT,
      ST_DONE
   } seq_state_t;

endpackage

// File: rtl/mont_mul.sv
// Bit-serial Montgomery product: res = a * b * 2^-W mod m
module mont_mul #(
   parameter int W = 12
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] m_i,
   output logic         done_o,
   output logic [W-1:0] res_o
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   generate
      if (W < 4) begin : g_bad_width
         $error("mont_mul: W must be at least 4");
      end
   endgenerate

   logic [W-1:0]  a_q, b_q, m_q;
   logic [W+1:0]  s_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, fin_q;

   logic [W+1:0]  add_b, add_m, s_nxt, diff;

   always_comb begin
      add_b = s_q + (a_q[0] ? {2'b00, b_q} : '0);
      add_m = add_b[0] ? (add_b + {2'b00, m_q}) : add_b;
      s_nxt = add_m >> 1;
      diff  = s_q - {2'b00, m_q};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_q    <= '0;
         b_q    <= '0;
         m_q    <= '0;
         s_q    <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         fin_q  <= 1'b0;
         done_o <= 1'b0;
         res_o  <= '0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            a_q   <= a_i;
            b_q   <= b_i;
            m_q   <= m_i;
            s_q   <= '0;
            cnt_q <= '0;
            run_q <= 1'b1;
            fin_q <= 1'b0;
         end else if (run_q) begin
            s_q   <= s_nxt;
            a_q   <= a_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end else if (fin_q) begin
            fin_q  <= 1'b0;
            done_o <= 1'b1;
            res_o  <= (s_q >= {2'b00, m_q}) ? diff[W-1:0] : s_q[W-1:0];
         end
      end
   end

   // Partial sum stays below 2m, so one subtraction reduces it fully
   assert_mm_reduced_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (res_o < m_q));

   assert_mm_sum_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> (s_q < {1'b0, m_q, 1'b0}));

endmodule

// File: rtl/power_bank.sv
// Register bank for precomputed powers: one write port, one mux read port
module power_bank #(
   parameter int W = 12,
   parameter int D = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [D-1:0] waddr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [D-1:0] raddr_i,
   output logic [W-1:0] rdata_o
);
   localparam int DEPTH = 2 ** D;

   logic [DEPTH-1:0]        wsel;
   logic [DEPTH-1:0][W-1:0] regs;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_entry
         logic [W-1:0] q;
         assign wsel[g] = we_i && (waddr_i == D'(g));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      q <= '0;
            else if (wsel[g]) q <= wdata_i;
         end
         assign regs[g] = q;
      end
   endgenerate

   assign rdata_o = regs[raddr_i];

   assert_bank_one_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(wsel));

endmodule

// File: rtl/window_sel.sv
// Holds the exponent and slices out the window chosen by the scan index
module window_sel #(
   parameter int W = 12,
   parameter int D = 4
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          load_i,
   input  logic [W-1:0]                  exp_i,
   input  logic [$clog2(W/D)-1:0]        idx_i,
   output logic [D-1:0]                  win_o,
   output logic                          zero_o
);
   localparam int NWIN = W / D;

   logic [W-1:0]               exp_q;
   logic [NWIN-1:0][D-1:0]     wins;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     exp_q <= '0;
      else if (load_i) exp_q <= exp_i;
   end

   generate
      for (genvar g = 0; g < NWIN; g++) begin : g_slice
         assign wins[g] = exp_q[g*D +: D];
      end
   endgenerate

   always_comb begin
      win_o = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (idx_i == ($clog2(W/D))'(i)) win_o = wins[i];
      end
      zero_o = (win_o == '0);
   end

endmodule

// File: rtl/modexp_window.sv
module modexp_window
   import modexp_pkg::*;
#(
   parameter int W = 12,
   parameter int D = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] base_i,
   input  logic [W-1:0] exp_i,
   input  logic [W-1:0] mod_i,
   input  logic [W-1:0] corr_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] result_o
);
   localparam int NWIN = W / D;
   localparam int IW   = $clog2(NWIN);
   localparam int SW   = $clog2(D);
   localparam logic [IW-1:0] FIRST_WIN = IW'(NWIN - 1);
   localparam logic [D-1:0]  TOP_POW   = {D{1'b1}};
   localparam logic [D-1:0]  BANK_OFS  = D'(2);
   localparam logic [SW-1:0] LAST_SQ   = SW'(D - 1);
   localparam logic [W-1:0]  ONE       = W'(1);

   generate
      if (W % D != 0) begin : g_bad_split
         $error("modexp_window: W must be a multiple of D");
      end
      if (D < 2 || NWIN < 2) begin : g_bad_window
         $error("modexp_window: need D >= 2 and at least two windows");
      end
   endgenerate

   seq_state_t state_q;

   logic [W-1:0]  mod_q, corr_q, xm_q, acc_q;
   logic [D-1:0]  pw_q;
   logic [IW-1:0] widx_q;
   logic [SW-1:0] sq_q;

   logic          mm_go_q, mm_done;
   logic [W-1:0]  op_a_q, op_b_q, mm_res;

   logic          accept;
   logic [D-1:0]  win;
   logic          win_zero;
   logic [W-1:0]  bank_rd, pow_sel;
   logic          bank_we;

   assign accept  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
   assign busy_o  = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign done_o  = (state_q == ST_DONE);
   assign bank_we = (state_q == ST_POWERS) && mm_done;
   assign pow_sel = (win == D'(1)) ? xm_q : bank_rd;

   mont_mul #(.W(W)) u_mm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (mm_go_q),
      .a_i     (op_a_q),
      .b_i     (op_b_q),
      .m_i     (mod_q),
      .done_o  (mm_done),
      .res_o   (mm_res)
   );

   power_bank #(.W(W), .D(D)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .waddr_i (pw_q - BANK_OFS),
      .wdata_i (mm_res),
      .raddr_i (win - BANK_OFS),
      .rdata_o (bank_rd)
   );

   window_sel #(.W(W), .D(D)) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (accept),
      .exp_i   (exp_i),
      .idx_i   (widx_q),
      .win_o   (win),
      .zero_o  (win_zero)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         mod_q    <= '0;
         corr_q   <= '0;
         xm_q     <= '0;
         acc_q    <= '0;
         pw_q     <= '0;
         widx_q   <= '0;
         sq_q     <= '0;
         mm_go_q  <= 1'b0;
         op_a_q   <= '0;
         op_b_q   <= '0;
         result_o <= '0;
      end else begin
         mm_go_q <= 1'b0;
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  mod_q   <= mod_i;
                  corr_q  <= corr_i;
                  op_a_q  <= base_i;
                  op_b_q  <= corr_i;
                  mm_go_q <= 1'b1;
                  state_q <= ST_TOMONT;
               end
            end
            ST_TOMONT: begin
               if (mm_done) begin
                  xm_q    <= mm_res;
                  op_a_q  <= corr_q;
                  op_b_q  <= ONE;
                  mm_go_q <= 1'b1;
                  state_q <= ST_ONE;
               end
            end
            ST_ONE: begin
               if (mm_done) begin
                  acc_q   <= mm_res;
                  op_a_q  <= xm_q;
                  op_b_q  <= xm_q;
                  pw_q    <= D'(2);
                  mm_go_q <= 1'b1;
                  state_q <= ST_POWERS;
               end
            end
            ST_POWERS: begin
               if (mm_done) begin
                  if (pw_q == TOP_POW) begin
                     widx_q  <= FIRST_WIN;
                     state_q <= ST_WINDOW;
                  end else begin
                     pw_q    <= pw_q + 1'b1;
                     op_a_q  <= mm_res;
                     op_b_q  <= xm_q;
                     mm_go_q <= 1'b1;
                  end
               end
            end
            ST_WINDOW: begin
               if (widx_q != FIRST_WIN) begin
                  sq_q    <= '0;
                  op_a_q  <= acc_q;
                  op_b_q  <= acc_q;
                  mm_go_q <= 1'b1;
                  state_q <= ST_SQUARE;
               end else if (!win_zero) begin
                  op_a_q  <= acc_q;
                  op_b_q  <= pow_sel;
                  mm_go_q <= 1'b1;
                  state_q <= ST_MULT;
               end else begin
                  widx_q  <= widx_q - 1'b1;
               end
            end
            ST_SQUARE: begin
               if (mm_done) begin
                  acc_q <= mm_res;
                  if (sq_q != LAST_SQ) begin
                     sq_q    <= sq_q + 1'b1;
                     op_a_q  <= mm_res;
                     op_b_q  <= mm_res;
                     mm_go_q <= 1'b1;
                  end else if (!win_zero) begin
                     op_a_q  <= mm_res;
                     op_b_q  <= pow_sel;
                     mm_go_q <= 1'b1;
                     state_q <= ST_MULT;
                  end else if (widx_q == '0) begin
                     op_a_q  <= mm_res;
                     op_b_q  <= ONE;
                     mm_go_q <= 1'b1;
                     state_q <= ST_FROMMONT;
                  end else begin
                     widx_q  <= widx_q - 1'b1;
                     state_q <= ST_WINDOW;
                  end
               end
            end
            ST_MULT: begin
               if (mm_done) begin
                  acc_q <= mm_res;
                  if (widx_q == '0) begin
                     op_a_q  <= mm_res;
                     op_b_q  <= ONE;
                     mm_go_q <= 1'b1;
                     state_q <= ST_FROMMONT;
                  end else begin
                     widx_q  <= widx_q - 1'b1;
                     state_q <= ST_WINDOW;
                  end
               end
            end
            ST_FROMMONT: begin
               if (mm_done) begin
                  result_o <= mm_res;
                  state_q  <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // A start seen mid-run neither aborts nor restarts the run
   assert_busy_ignores_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i) |=> (busy_o || done_o));

   assert_done_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> done_o);

   assert_start_clears_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && start_i) |=> (busy_o && !done_o));

   assert_result_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> $stable(result_o));

   assert_result_below_mod_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (result_o < mod_q));

   // Multiplies are never issued for a zero window
   assert_zero_window_no_mult_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_WINDOW && widx_q == FIRST_WIN && win_zero) |=> (state_q == ST_WINDOW));

   assert_bank_read_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_MULT && mm_go_q) |-> (win != '0));

endmodule

// File: tb/sim_modexp_window.sv
module sim_modexp_window;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] base = '0, expo = '0, modu = '0, corr = '0;
   logic         busy, done;
   logic [W-1:0] res;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   modexp_window #(.W(W), .D(4)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .base_i(base), .exp_i(expo), .mod_i(modu), .corr_i(corr),
      .busy_o(busy), .done_o(done), .result_o(res)
   );

   // {X, Y, M, Z}
   localparam int NV = 8;
   localparam logic [47:0] VEC [NV] = '{
      {12'd1697, 12'd25,   12'd2773, 12'd1197},
      {12'd2000, 12'd140,  12'd2901, 12'd982},
      {12'd83,   12'd137,  12'd2497, 12'd283},
      {12'd283,  12'd33,   12'd2497, 12'd83},
      {12'd0,    12'd5,    12'd2773, 12'd0},
      {12'd1,    12'd4095, 12'd2901, 12'd1},
      {12'd2772, 12'd2,    12'd2773, 12'd1},
      {12'd5,    12'd0,    12'd2497, 12'd1}
   };

   function automatic longint ref_pow(longint x, longint y, longint m);
      longint r = 1;
      longint b = x % m;
      for (int i = 0; i < 12; i++) begin
         if ((y >> i) & 1) r = (r * b) % m;
         b = (b * b) % m;
      end
      return r % m;
   endfunction

   task automatic check(string req, longint act, longint exp_v);
      checks++;
      if (act != exp_v) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic run(input int x, input int y, input int m, output int z, output int lat);
      @(negedge clk);
      base  = W'(x);
      expo  = W'(y);
      modu  = W'(m);
      corr  = W'((64'd1 << 24) % 64'(m));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 4000) begin
         @(negedge clk);
         lat++;
      end
      if (!done) begin
         failures++;
         $display("FAIL R1 run timed out actual=busy expected=done");
      end
      z = int'(res);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int z, lat, la, lb, lc, ld, zsave;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 busy", busy, 0);
      check("R10 done", done, 0);
      check("R10 result", res, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R6 / R7: vector table
      for (int i = 0; i < NV; i++) begin
         run(int'(VEC[i][47:36]), int'(VEC[i][35:24]), int'(VEC[i][23:12]), z, lat);
         check("R1 table", z, int'(VEC[i][11:0]));
         check("R1 model", z, ref_pow(VEC[i][47:36], VEC[i][35:24], VEC[i][23:12]));
      end

      // R9: every window value 1..15 picks the right power
      for (int k = 1; k < 16; k++) begin
         run(1697, k, 2773, z, lat);
         check("R9 window value", z, ref_pow(1697, k, 2773));
      end
      run(1234, 12'hFED, 2901, z, lat);
      check("R9 mixed windows", z, ref_pow(1234, 12'hFED, 2901));

      // R3 / R4: done holds, result steady
      run(83, 137, 2497, z, lat);
      zsave = z;
      repeat (50) @(negedge clk);
      check("R3 done held", done, 1);
      check("R3 busy low", busy, 0);
      check("R4 result stable", res, zsave);

      // R2: start mid-run with other operands is ignored
      @(negedge clk);
      base = 12'd283; expo = 12'd33; modu = 12'd2497;
      corr = W'((64'd1 << 24) % 64'd2497);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R3 done falls after start", done, 0);
      check("R3 busy after start", busy, 1);
      repeat (30) @(negedge clk);
      base = 12'd1697; expo = 12'd25; modu = 12'd2773; corr = 12'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 4000) begin
         @(negedge clk);
         lat++;
      end
      check("R2 ignored start result", res, 83);

      // R5: zero windows skip the multiply
      run(2000, 12'h100, 2901, z, la);
      check("R5 result a", z, ref_pow(2000, 12'h100, 2901));
      run(2000, 12'h101, 2901, z, lb);
      run(2000, 12'h010, 2901, z, lc);
      run(2000, 12'h011, 2901, z, ld);
      check("R5 delta positive", (lb > la) ? 1 : 0, 1);
      check("R5 equal deltas", lb - la, ld - lc);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule